// File: doc/BRIEF.md
# Keyboard Command Responder

This block is the device side of a PC keyboard's command handling. The host controller hands it one command byte at a time. For each accepted byte it decides what to answer and pushes zero, one or two reply bytes into the controller's keyboard queue. When there are two replies, they go out on back-to-back cycles.

The block keeps two pieces of state. The first is a scan-enable flag, which it drives out to the scan logic. The second is a one-byte pending-argument state. Two commands use it: light setting and typematic rate setting. Each of these is answered only once its parameter byte has arrived.

While the second reply of a pair is still owed, the block raises busy. It also drops its ready output, so the controller holds the next byte until busy clears.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset, rsp_valid_o and busy_o are 0, cmd_ready_o is 1, scan_en_o equals parameter SCAN_EN_RST (default 1), and no argument is pending.
- R2: With nothing pending, byte 0x00 or any byte not named in R3 to R7 gives exactly one reply, 0xFA (acknowledge).
- R3: With nothing pending, 0xED or 0xF3 gives no reply and makes the next accepted byte an argument. That byte, whatever its value, is answered with a single 0xFA and leaves scan_en_o unchanged. Pending returns to none after every accepted byte.
- R4: With nothing pending, 0xF4 and 0xF6 set scan_en_o and 0xF5 clears it. Each of them replies with a single 0xFA.
- R5: With nothing pending, 0xFF sets scan_en_o and replies 0xFA and then 0xAA on consecutive cycles. busy_o is 1 in the cycle that carries the first of the two.
- R6: With nothing pending, 0xEE is answered with one byte, 0xEE.
- R7: With nothing pending, 0x05 is answered with one byte, 0xFE (resend).
- R8: While busy_o is 1, cmd_ready_o is 0. A byte presented in that cycle is not accepted and has no effect on replies, pending state or scan_en_o.
- R9: A byte is accepted on a rising clock edge when cmd_valid_i and cmd_ready_o are both 1. Its first reply is valid in the cycle that follows that edge. rsp_valid_o is 1 only for replies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command byte is presented |
| cmd_byte_i | input | 8 | Command or argument byte |
| cmd_ready_o | output | 1 | The block can accept a byte this cycle |
| rsp_valid_o | output | 1 | Push strobe for the reply byte |
| rsp_byte_o | output | 8 | Reply byte |
| busy_o | output | 1 | A second reply byte is still owed |
| scan_en_o | output | 1 | Scan-enable flag |

## Verification
The bench builds the block with its default parameters. SCAN_EN_RST is therefore 1, which fixes the reset value of scan_en_o that the first check expects. It runs a fixed-seed random byte stream, weighted towards the named command values and towards argument commands followed by reserved values such as 0xFF and 0xF5. This brings the argument-absorbs-command case within reach repeatedly, along with clears and sets of scan-enable in both orders. After each full reset command it presents a random byte while busy, which checks hold-off on every two-reply sequence.

// File: rtl/kbd_rsp_pkg.sv
package kbd_rsp_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] RSP_ACK    = 8'hFA;
  localparam logic [BYTE_W-1:0] RSP_RESEND = 8'hFE;
  localparam logic [BYTE_W-1:0] RSP_POR    = 8'hAA;

  localparam logic [BYTE_W-1:0] CMD_LEDS   = 8'hED;
  localparam logic [BYTE_W-1:0] CMD_ECHO   = 8'hEE;
  localparam logic [BYTE_W-1:0] CMD_RATE   = 8'hF3;
  localparam logic [BYTE_W-1:0] CMD_SC_ON  = 8'hF4;
  localparam logic [BYTE_W-1:0] CMD_RST_OFF= 8'hF5;
  localparam logic [BYTE_W-1:0] CMD_RST_ON = 8'hF6;
  localparam logic [BYTE_W-1:0] CMD_RESET  = 8'hFF;
  localparam logic [BYTE_W-1:0] CMD_NULL   = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_BAD    = 8'h05;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_LEDS = 2'd1,
    PEND_RATE = 2'd2
  } pend_e;

  typedef struct packed {
    logic [1:0]        n_rsp;
    logic [BYTE_W-1:0] rsp0;
    logic [BYTE_W-1:0] rsp1;
    logic              scan_set;
    logic              scan_clr;
    pend_e             next_pend;
  } decode_t;
endpackage

// File: rtl/kbd_rsp_decode.sv
module kbd_rsp_decode
  import kbd_rsp_pkg::*;
(
  input  pend_e             pend_i,
  input  logic [BYTE_W-1:0] byte_i,
  output decode_t           dec_o
);
  always_comb begin
    dec_o           = '0;
    dec_o.next_pend = PEND_NONE;
    dec_o.n_rsp     = 2'd1;
    dec_o.rsp0      = RSP_ACK;
    if (pend_i != PEND_NONE) begin
      // argument byte: acknowledged whatever its value
      dec_o.n_rsp = 2'd1;
    end else begin
      unique case (byte_i)
        CMD_LEDS: begin
          dec_o.n_rsp     = 2'd0;
          dec_o.next_pend = PEND_LEDS;
        end
        CMD_RATE: begin
          dec_o.n_rsp     = 2'd0;
          dec_o.next_pend = PEND_RATE;
        end
        CMD_ECHO:    dec_o.rsp0 = CMD_ECHO;
        CMD_BAD:     dec_o.rsp0 = RSP_RESEND;
        CMD_SC_ON:   dec_o.scan_set = 1'b1;
        CMD_RST_ON:  dec_o.scan_set = 1'b1;
        CMD_RST_OFF: dec_o.scan_clr = 1'b1;
        CMD_RESET: begin
          dec_o.scan_set = 1'b1;
          dec_o.n_rsp    = 2'd2;
          dec_o.rsp1     = RSP_POR;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kbd_rsp_state.sv
module kbd_rsp_state
  import kbd_rsp_pkg::*;
#(
  parameter logic SCAN_EN_RST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  decode_t           dec_i,
  output pend_e             pend_o,
  output logic              scan_en_o
);
  pend_e pend_q;
  logic  scan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= PEND_NONE;
      scan_q <= SCAN_EN_RST;
    end else if (accept_i) begin
      pend_q <= dec_i.next_pend;
      if (dec_i.scan_set)      scan_q <= 1'b1;
      else if (dec_i.scan_clr) scan_q <= 1'b0;
    end
  end

  assign pend_o    = pend_q;
  assign scan_en_o = scan_q;

  AST_PEND_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && pend_q != PEND_NONE |=> pend_q == PEND_NONE); // R3
  AST_ARG_KEEPS_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && pend_q != PEND_NONE |=> $stable(scan_q)); // R3
  AST_SCAN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && pend_q == PEND_NONE && byte_i == CMD_RST_OFF |=> !scan_q); // R4
  AST_SCAN_ON_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && pend_q == PEND_NONE && byte_i == CMD_RESET |=> scan_q); // R5
endmodule

// File: rtl/kbd_rsp_seq.sv
module kbd_rsp_seq
  import kbd_rsp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  decode_t           dec_i,
  output logic              rsp_valid_o,
  output logic [BYTE_W-1:0] rsp_byte_o,
  output logic              busy_o
);
  logic              hold_q;
  logic [BYTE_W-1:0] hold_byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_byte_o  <= '0;
      hold_q      <= 1'b0;
      hold_byte_q <= '0;
    end else if (accept_i) begin
      rsp_valid_o <= dec_i.n_rsp != 2'd0;
      rsp_byte_o  <= dec_i.rsp0;
      hold_q      <= dec_i.n_rsp == 2'd2;
      hold_byte_q <= dec_i.rsp1;
    end else if (hold_q) begin
      rsp_valid_o <= 1'b1;
      rsp_byte_o  <= hold_byte_q;
      hold_q      <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
    end
  end

  assign busy_o = hold_q;

  AST_BUSY_WITH_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rsp_valid_o && rsp_byte_o == RSP_ACK); // R5
  AST_SECOND_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> rsp_valid_o && rsp_byte_o == RSP_POR && !busy_o); // R5
  AST_NO_REPLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i && !busy_o |=> !rsp_valid_o); // R9
endmodule

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder
  import kbd_rsp_pkg::*;
#(
  parameter logic SCAN_EN_RST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] cmd_byte_i,
  output logic              cmd_ready_o,
  output logic              rsp_valid_o,
  output logic [BYTE_W-1:0] rsp_byte_o,
  output logic              busy_o,
  output logic              scan_en_o
);
  pend_e   pend;
  decode_t dec;
  logic    accept;

  assign cmd_ready_o = !busy_o;
  assign accept      = cmd_valid_i && cmd_ready_o;

  kbd_rsp_decode u_decode (
    .pend_i (pend),
    .byte_i (cmd_byte_i),
    .dec_o  (dec)
  );

  kbd_rsp_state #(.SCAN_EN_RST(SCAN_EN_RST)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .byte_i    (cmd_byte_i),
    .dec_i     (dec),
    .pend_o    (pend),
    .scan_en_o (scan_en_o)
  );

  kbd_rsp_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .dec_i       (dec),
    .rsp_valid_o (rsp_valid_o),
    .rsp_byte_o  (rsp_byte_o),
    .busy_o      (busy_o)
  );

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmd_valid_i |=> $stable(scan_en_o) && !busy_o); // R8
  AST_ACCEPT_REPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && pend == PEND_NONE && cmd_byte_i == CMD_ECHO
    |=> rsp_valid_o && rsp_byte_o == CMD_ECHO); // R6
endmodule

// File: tb/kbd_cmd_responder_test.sv
module kbd_cmd_responder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       cmd_ready, rsp_valid, busy, scan_en;
  logic [7:0] rsp_byte;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit m_pend = 1'b0;
  bit m_scan = 1'b1;

  always #5 clk = ~clk;

  kbd_cmd_responder uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte),
    .cmd_ready_o(cmd_ready), .rsp_valid_o(rsp_valid), .rsp_byte_o(rsp_byte),
    .busy_o(busy), .scan_en_o(scan_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model(input bit pend, input bit scan, input logic [7:0] b,
                                output int n, output logic [7:0] r0, output logic [7:0] r1,
                                output bit npend, output bit nscan, output string req);
    n = 1; r0 = 8'hFA; r1 = 8'h00; npend = 1'b0; nscan = scan; req = "R2";
    if (pend) begin
      req = "R3";
    end else begin
      case (b)
        8'hED, 8'hF3: begin n = 0; npend = 1'b1; req = "R3"; end
        8'hEE: begin r0 = 8'hEE; req = "R6"; end
        8'h05: begin r0 = 8'hFE; req = "R7"; end
        8'hF4, 8'hF6: begin nscan = 1'b1; req = "R4"; end
        8'hF5: begin nscan = 1'b0; req = "R4"; end
        8'hFF: begin n = 2; r1 = 8'hAA; nscan = 1'b1; req = "R5"; end
        default: ;
      endcase
    end
  endfunction

  task automatic send(input logic [7:0] b);
    int n; logic [7:0] r0, r1; bit np, ns; string req;
    model(m_pend, m_scan, b, n, r0, r1, np, ns, req);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R8 ready", cmd_ready, 1);
    check(rsp_valid == 1'b0, "R9 idle", rsp_valid, 0);
    cmd_valid = 1'b1;
    cmd_byte = b;
    @(negedge clk);
    if (n == 0) begin
      check(rsp_valid == 1'b0, "R3 no reply", rsp_valid, 0);
    end else begin
      check(rsp_valid == 1'b1, {req, " valid"}, rsp_valid, 1);
      check(rsp_byte == r0, {req, " first"}, rsp_byte, r0);
    end
    check(busy == (n == 2), "R5 busy", busy, n == 2);
    if (n == 2) begin
      cmd_byte = 8'($urandom);
      check(cmd_ready == 1'b0, "R8 held", cmd_ready, 0);
      @(negedge clk);
      check(rsp_valid == 1'b1 && rsp_byte == r1, "R5 second", rsp_byte, r1);
      check(busy == 1'b0, "R5 busy clear", busy, 0);
    end
    cmd_valid = 1'b0;
    check(scan_en == ns, {req, " scan"}, scan_en, ns);
    m_pend = np;
    m_scan = ns;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] picks [12];
    picks = '{8'h00, 8'h05, 8'hED, 8'hEE, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hFF, 8'h42, 8'hF2, 8'hAA};
    void'($urandom(32'd1234));
    #23;
    // R1 reset state
    check(rsp_valid == 1'b0, "R1 valid", rsp_valid, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    check(scan_en == 1'b1, "R1 scan", scan_en, 1);
    rst_n = 1'b1;
    // directed corners
    send(8'h00);           // R2
    send(8'h05);           // R7
    send(8'hEE);           // R6
    send(8'hF5);           // R4 clear
    send(8'hED); send(8'hFF);  // R3 argument absorbs reset
    send(8'hF3); send(8'hF4);  // R3 argument absorbs enable
    send(8'hFF);           // R5
    send(8'hF5); send(8'hF6);  // R4
    send(8'h42);           // R2
    send(8'hED); send(8'hED); send(8'hEE); // R3 pending cleared by argument
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(3) == 0) send(8'($urandom));
      else send(picks[$urandom_range(11)]);
    end
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 final idle", rsp_valid, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule